// File: doc/BRIEF.md
# Vector Element Table Lookup Unit

This block is a permute unit for a vector datapath. A lookup table is formed from one vector operand, or from two operands joined end to end, and every element of the destination is filled with the table element chosen by the element in the same position of an index vector. The element width is chosen per operation by a two-bit size code. Any index that points past the end of the table gives a zero element.

An operation starts with a one-cycle start strobe that comes with the operands. One clock edge later the result vector is registered and a done strobe rises for exactly one cycle. The result stays unchanged until the next start. The vector length is a build-time parameter. For two-table operation the surrounding datapath also needs the number of the register that holds the upper table half. The block computes it as the first table register number plus one, wrapping at the top of the register space.

Top module: `tlu_top`

## Requirements
- R1: Result element e equals table element k, where k is the unsigned value of index element e at the current element width. Element e occupies bits [e*W +: W] of every vector, and table element k occupies bits [k*W +: W] of the table.
- R2: The size code selects the element width W: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: When k is greater than or equal to the number of table elements, result element e is all zeros.
- R4: With the dual select at 1, the table is {upper, lower}. The lower operand supplies table elements 0 to VLEN/W-1 and the upper operand supplies elements VLEN/W to 2*VLEN/W-1.
- R5: With the dual select at 0, the table holds VLEN/W elements taken from the lower operand only. The upper operand has no effect, and indices from VLEN/W upward give zero.
- R6: The index is compared at its full element width, so large values (all ones, or values above 2^32) give zero and never wrap back into range.
- R7: The done strobe is 1 in exactly the cycle after a start and is 0 in all other cycles.
- R8: The result holds its value in every cycle that follows a cycle without start.
- R9: An active-low synchronous reset clears the result and done.
- R10: The upper-table register number output equals the first table register number plus one, modulo 2^REGW. With REGW=5, 31 gives 0.
- R11: Every result element is written on each operation, and no element keeps a value from an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle operation request |
| esize_i | input | 2 | Element size code |
| dual_i | input | 1 | 1 selects a two-vector table |
| tbl_lo_i | input | VLEN | Lower (or only) table vector |
| tbl_hi_i | input | VLEN | Upper table vector |
| idx_i | input | VLEN | Index vector |
| tbl_reg_i | input | REGW | Register number of the lower table vector |
| next_reg_o | output | REGW | Register number of the upper table vector |
| result_o | output | VLEN | Registered lookup result |
| done_o | output | 1 | Result-valid strobe, one cycle |

## Verification
The only state is the result register and the done flag, so a fault appears at the ports on the edge right after the start that caused it. A wrong size path or a bad range compare shows up as a wrong element value at the next done. A stuck or stretched done, or a result that changes without a start, is visible one cycle later. The bench uses mixed in-range and out-of-range indices at every size, in both table modes. Each result is compared against a reference loop that walks every element, which exposes a single bad lane, a swapped table half or a wrapped index.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

   localparam int NUM_SIZES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } tlu_esize_e;

   function automatic int esize_bits(input int code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/tlu_size_path.sv
module tlu_size_path #(
   parameter int VLEN = 256,
   parameter int ESZ  = 8
) (
   input  logic              dual_i,
   input  logic [2*VLEN-1:0] table_i,
   input  logic [VLEN-1:0]   idx_i,
   output logic [VLEN-1:0]   res_o
);
   localparam int NE = VLEN / ESZ;
   localparam int TE = 2 * NE;
   localparam int SW = $clog2(TE);
   localparam int CW = (ESZ > SW + 1) ? ESZ : SW + 1;

   if (VLEN % ESZ != 0) begin : g_bad_esz
      $error("tlu_size_path: VLEN must be a multiple of ESZ");
   end

   for (genvar e = 0; e < NE; e++) begin : g_elem
      logic [ESZ-1:0] ix;
      logic [CW-1:0]  ixw;
      logic [SW-1:0]  sel;
      logic           in_rng;

      assign ix     = idx_i[e*ESZ +: ESZ];
      assign ixw    = CW'(ix);
      assign sel    = SW'(ixw);
      assign in_rng = dual_i ? (ixw < CW'(TE)) : (ixw < CW'(NE));
      assign res_o[e*ESZ +: ESZ] = in_rng ? table_i[sel*ESZ +: ESZ] : '0;
   end

endmodule

// File: rtl/tlu_out_reg.sv
module tlu_out_reg #(
   parameter int W = 256
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic         done_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_o    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= load_i;
         if (load_i) begin
            q_o <= d_i;
         end
      end
   end

endmodule

// File: rtl/tlu_top.sv
module tlu_top #(
   parameter int VLEN = 256,
   parameter int REGW = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [1:0]      esize_i,
   input  logic            dual_i,
   input  logic [VLEN-1:0] tbl_lo_i,
   input  logic [VLEN-1:0] tbl_hi_i,
   input  logic [VLEN-1:0] idx_i,
   input  logic [REGW-1:0] tbl_reg_i,
   output logic [REGW-1:0] next_reg_o,
   output logic [VLEN-1:0] result_o,
   output logic            done_o
);
   import tlu_pkg::*;

   localparam int TW = 2 * VLEN;

   if (VLEN < 64 || VLEN % 64 != 0) begin : g_bad_vlen
      $error("tlu_top: VLEN must be a nonzero multiple of 64");
   end
   if (REGW < 1) begin : g_bad_regw
      $error("tlu_top: REGW must be at least 1");
   end

   logic [TW-1:0]   table_w;
   logic [VLEN-1:0] path_res [NUM_SIZES];
   logic [VLEN-1:0] sel_res;

   assign table_w = {tbl_hi_i, tbl_lo_i};

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      tlu_size_path #(
         .VLEN (VLEN),
         .ESZ  (esize_bits(s))
      ) u_path (
         .dual_i  (dual_i),
         .table_i (table_w),
         .idx_i   (idx_i),
         .res_o   (path_res[s])
      );
   end

   always_comb begin
      case (tlu_esize_e'(esize_i))
         SZ_BYTE: sel_res = path_res[0];
         SZ_HALF: sel_res = path_res[1];
         SZ_WORD: sel_res = path_res[2];
         default: sel_res = path_res[3];
      endcase
   end

   assign next_reg_o = tbl_reg_i + REGW'(1);

   tlu_out_reg #(
      .W (VLEN)
   ) u_oreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_i),
      .d_i    (sel_res),
      .q_o    (result_o),
      .done_o (done_o)
   );

endmodule

// File: rtl/tlu_chk.sv
module tlu_chk #(
   parameter int VLEN = 256,
   parameter int REGW = 5
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            start_i,
   input logic [1:0]      esize_i,
   input logic            dual_i,
   input logic [VLEN-1:0] tbl_hi_i,
   input logic [VLEN-1:0] idx_i,
   input logic [REGW-1:0] tbl_reg_i,
   input logic [REGW-1:0] next_reg_o,
   input logic [VLEN-1:0] result_o,
   input logic            done_o
);
   localparam logic [63:0] NE64 = 64'(VLEN / 64);

   AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> done_o); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> !done_o); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(result_o)); // R8
   AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && esize_i == 2'b11 && idx_i[63:0] >= (dual_i ? 2*NE64 : NE64))
      |=> result_o[63:0] == 64'd0); // R3
   AST_DUAL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && esize_i == 2'b11 && dual_i && idx_i[63:0] == NE64)
      |=> result_o[63:0] == $past(tbl_hi_i[63:0])); // R4
   AST_REG_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tbl_reg_i == '1) |-> next_reg_o == '0); // R10

endmodule

bind tlu_top tlu_chk #(.VLEN(VLEN), .REGW(REGW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .esize_i    (esize_i),
   .dual_i     (dual_i),
   .tbl_hi_i   (tbl_hi_i),
   .idx_i      (idx_i),
   .tbl_reg_i  (tbl_reg_i),
   .next_reg_o (next_reg_o),
   .result_o   (result_o),
   .done_o     (done_o)
);

// File: tb/tlu_top_bench.sv
`timescale 1ns/1ps
module tlu_top_bench;
   localparam int VLEN = 256;
   localparam int REGW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      esize = 2'b00;
   logic            dual = 1'b0;
   logic [VLEN-1:0] lo = '0, hi = '0, idx = '0;
   logic [REGW-1:0] treg = '0;
   logic [REGW-1:0] nreg;
   logic [VLEN-1:0] res;
   logic            done;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   tlu_top #(.VLEN(VLEN), .REGW(REGW)) u_tlu_top (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .esize_i(esize),
      .dual_i(dual), .tbl_lo_i(lo), .tbl_hi_i(hi), .idx_i(idx),
      .tbl_reg_i(treg), .next_reg_o(nreg), .result_o(res), .done_o(done)
   );

   function automatic logic [VLEN-1:0] ref_lookup(input logic [1:0] sz, input logic dl,
      input logic [VLEN-1:0] tlo, input logic [VLEN-1:0] thi, input logic [VLEN-1:0] tix);
      int esz = 8 << sz;
      int ne  = VLEN / esz;
      int cnt = dl ? 2*ne : ne;
      logic [2*VLEN-1:0] tb = {thi, tlo};
      logic [VLEN-1:0] r = '0;
      for (int e = 0; e < ne; e++) begin
         logic [63:0] iv = '0;
         for (int b = 0; b < esz; b++) iv[b] = tix[e*esz+b];
         if (iv < 64'(cnt))
            for (int b = 0; b < esz; b++) r[e*esz+b] = tb[int'(iv)*esz+b];
      end
      return r;
   endfunction

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [VLEN-1:0] mk_idx(input logic [1:0] sz, input int base, input int span);
      int esz = 8 << sz;
      logic [VLEN-1:0] v = '0;
      for (int e = 0; e < VLEN/esz; e++) begin
         logic [63:0] iv = 64'(base) + 64'($urandom % span);
         for (int b = 0; b < esz; b++) v[e*esz+b] = iv[b];
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] sz, input logic dl, input logic [VLEN-1:0] tlo,
      input logic [VLEN-1:0] thi, input logic [VLEN-1:0] tix, input string req);
      logic [VLEN-1:0] exp = ref_lookup(sz, dl, tlo, thi, tix);
      @(negedge clk);
      esize = sz; dual = dl; lo = tlo; hi = thi; idx = tix; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R7", "done after start", VLEN'(done), VLEN'(1));
      chk(res === exp, req, "result", res, exp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(res === '0, "R9", "result in reset", res, '0);
      chk(done === 1'b0, "R9", "done in reset", VLEN'(done), '0);
   endtask

   task automatic t_sizes();
      for (int s = 0; s < 4; s++) begin
         int ne = VLEN / (8 << s);
         do_op(2'(s), 1'b0, rnd_vec(), rnd_vec(), mk_idx(2'(s), 0, ne + ne/2), "R1 R2 R3");
         do_op(2'(s), 1'b1, rnd_vec(), rnd_vec(), mk_idx(2'(s), 0, 3*ne), "R1 R2 R4");
      end
   endtask

   task automatic t_single_hi_ignored();
      logic [VLEN-1:0] a = rnd_vec();
      logic [VLEN-1:0] ix = mk_idx(2'b01, VLEN/16, VLEN/16);
      do_op(2'b01, 1'b0, a, rnd_vec(), ix, "R5");
      chk(res === '0, "R5", "upper ignored in single mode", res, '0);
      ix = mk_idx(2'b01, 0, VLEN/16);
      do_op(2'b01, 1'b0, a, '1, ix, "R5");
   endtask

   task automatic t_dual_order();
      logic [VLEN-1:0] a = rnd_vec();
      logic [VLEN-1:0] b = rnd_vec();
      logic [VLEN-1:0] ix = '0;
      ix[31:0] = 32'(VLEN/32);
      ix[63:32] = 32'(VLEN/32 - 1);
      do_op(2'b10, 1'b1, a, b, ix, "R4");
      chk(res[31:0] === b[31:0], "R4", "element 0 from upper", VLEN'(res[31:0]), VLEN'(b[31:0]));
      chk(res[63:32] === a[VLEN-1 -: 32], "R4", "element 1 from lower top",
          VLEN'(res[63:32]), VLEN'(a[VLEN-1 -: 32]));
   endtask

   task automatic t_huge();
      logic [VLEN-1:0] ix = '0;
      do_op(2'b00, 1'b1, rnd_vec(), rnd_vec(), '1, "R6");
      for (int e = 0; e < VLEN/64; e++) ix[e*64 +: 64] = (64'd1 << 32) | 64'(e);
      do_op(2'b11, 1'b1, rnd_vec(), rnd_vec(), ix, "R6");
      chk(res === '0, "R6", "no wrap above 2^32", res, '0);
   endtask

   task automatic t_hold();
      logic [VLEN-1:0] keep;
      do_op(2'b00, 1'b0, rnd_vec(), rnd_vec(), mk_idx(2'b00, 0, 32), "R1");
      keep = res;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         lo = rnd_vec(); hi = rnd_vec(); idx = rnd_vec(); esize = 2'(i);
         @(negedge clk);
         chk(res === keep, "R8", "hold without start", res, keep);
         chk(done === 1'b0, "R7", "done low", VLEN'(done), '0);
      end
   endtask

   task automatic t_overwrite();
      do_op(2'b00, 1'b0, '1, '1, '0, "R11");
      do_op(2'b10, 1'b0, '1, '1, '1, "R11");
      chk(res === '0, "R11", "all elements rewritten", res, '0);
   endtask

   task automatic t_next_reg();
      treg = 5'd31; #1;
      chk(nreg === 5'd0, "R10", "wrap 31", VLEN'(nreg), VLEN'(0));
      treg = 5'd7; #1;
      chk(nreg === 5'd8, "R10", "7 plus 1", VLEN'(nreg), VLEN'(8));
   endtask

   task automatic t_reset_mid();
      do_op(2'b01, 1'b0, '1, '1, '0, "R1");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk(res === '0, "R9", "result cleared", res, '0);
      chk(done === 1'b0, "R9", "done cleared", VLEN'(done), '0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_sizes();
      t_single_hi_ignored();
      t_dual_order();
      t_huge();
      t_hold();
      t_overwrite();
      t_next_reg();
      t_reset_mid();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule